// File: doc/BRIEF.md
# Immediate-Offset Byte/Word Load-Store Unit

This unit carries out a single family of 16-bit compressed memory instructions. Each one moves either a 32-bit word or an 8-bit byte between one of eight general registers and memory, at an address equal to a base register plus a small constant taken from the instruction. When the access is a word access, the 5-bit constant counts words and is multiplied by four. When it is a byte access, the constant counts bytes and is used unchanged.

An instruction is offered on `instrWord` and qualified by `instrValid`. The unit takes it only while idle. It reads the base and data registers through a two-address combinational read port. It then issues one request on a single-ported synchronous memory, which answers reads one cycle later. For a load, the unit returns a register write-back. Instructions whose major opcode does not belong to this family are dropped without any side effect.

Top module: `lsImmUnit`

## Requirements
- R1: Instruction bit 11 picks the direction. A value of 0 is a store: memory is written with `memWe`=1 and no write-back follows. A value of 1 is a load: memory is read and the destination register is written.
- R2: Instruction bit 12 picks the size. A value of 0 is a word access with all four byte enables high. A value of 1 is a byte access with exactly one byte enable high.
- R3: In a word access, the address is the base register plus the offset field (bits 10:6) times four. For example, a field of 29 adds 116, and the largest reachable offset is 124.
- R4: In a byte access, the address is the base register plus the offset field unscaled, so a field of 13 adds 13.
- R5: Memory is little-endian. A byte store asserts only enable bit `addr[1:0]` and places bits 7:0 of the source register (bits 2:0 of the instruction) on that lane of `memWdata`. The other bytes of the memory word are unchanged.
- R6: A byte load takes the byte from lane `addr[1:0]` of the read data and zero-extends it to 32 bits.
- R7: The memory request lasts one cycle and begins in the cycle after the instruction is accepted. A load raises `wbEn`, with `wbIdx` equal to bits 2:0 of the instruction, in the cycle where `memRdValid` is high, which is one cycle after the request.
- R8: An instruction is accepted only when bits 15:13 equal 3'b011. Any other value in those bits produces no memory request and leaves `busy` low.
- R9: `busy` is high from the cycle after acceptance until the access completes. An instruction offered while `busy` is high is ignored.
- R10: After reset, `busy`, `memReq` and `wbEn` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Instruction offered this cycle |
| instrWord | input | 16 | Instruction halfword |
| busy | output | 1 | Access in progress |
| rfBaseIdx | output | 3 | Register read address for the base |
| rfBaseData | input | 32 | Base register value |
| rfDataIdx | output | 3 | Register read address for the store source |
| rfDataData | input | 32 | Store source value |
| memReq | output | 1 | Memory request, one cycle |
| memWe | output | 1 | Write enable for the request |
| memBe | output | 4 | Byte enables |
| memAddr | output | 32 | Byte address |
| memWdata | output | 32 | Write data, byte lane aligned |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| wbEn | output | 1 | Register write-back strobe |
| wbIdx | output | 3 | Write-back register index |
| wbData | output | 32 | Write-back value |

## Verification
The assertions assume that the memory raises `memRdValid` only in the cycle after a read request, and never after a write. The behavioural memory in the bench keeps to that rule exactly. They also assume that word accesses use word-aligned bases, since misaligned access is outside this block; the bench gives every word access an aligned base. Busy-time stimulus is deliberately offered while an access is in flight, which lets the bench show that it leaves no trace.

// File: rtl/lsImmPkg.sv
package lsImmPkg;
  localparam int XLEN = 32;
  localparam int REG_IDX_W = 3;
  localparam logic [2:0] MAJOR_OP = 3'b011;

  typedef struct packed {
    logic loadInstr;   // capture the offered instruction
    logic issueAccess; // drive the memory request
    logic captureLane; // remember address low bits for the read return
  } lsStrobe_t;
endpackage

// File: rtl/lsImmCtrl.sv
module lsImmCtrl
  import lsImmPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrValid,
  input  logic [2:0] majorOp,
  input  logic       isLoad,
  input  logic       memRdValid,
  output lsStrobe_t  strobe,
  output logic       busy,
  output logic       wbEn
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_WAIT} state_t;
  state_t state, stateNext;

  logic accept;
  assign accept = (state == ST_IDLE) && instrValid && (majorOp == MAJOR_OP);

  always_comb begin
    stateNext = state;
    strobe = '0;
    wbEn = 1'b0;
    case (state)
      ST_IDLE: begin
        strobe.loadInstr = accept;
        if (accept) stateNext = ST_ACCESS;
      end
      ST_ACCESS: begin
        strobe.issueAccess = 1'b1;
        strobe.captureLane = 1'b1;
        stateNext = isLoad ? ST_WAIT : ST_IDLE;
      end
      ST_WAIT: begin
        if (memRdValid) begin
          wbEn = 1'b1;
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/lsImmDatapath.sv
module lsImmDatapath
  import lsImmPkg::*;
#(
  parameter int DW = XLEN,
  parameter int RW = REG_IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  lsStrobe_t         strobe,
  input  logic [15:0]       instrWord,
  output logic [2:0]        majorOp,
  output logic              isLoad,
  output logic [RW-1:0]     rfBaseIdx,
  input  logic [DW-1:0]     rfBaseData,
  output logic [RW-1:0]     rfDataIdx,
  input  logic [DW-1:0]     rfDataData,
  output logic              memReq,
  output logic              memWe,
  output logic [DW/8-1:0]   memBe,
  output logic [DW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  input  logic [DW-1:0]     memRdData,
  output logic [RW-1:0]     wbIdx,
  output logic [DW-1:0]     wbData
);
  localparam int LANES  = DW / 8;
  localparam int LANE_W = $clog2(LANES);

  logic [15:0]       instrQ;
  logic [LANE_W-1:0] laneQ;
  logic              isByte;
  logic [4:0]        offField;
  logic [DW-1:0]     offBytes;
  logic [LANE_W-1:0] lane;
  logic [DW-1:0]     shiftedRd;

  assign majorOp   = instrWord[15:13];
  assign isByte    = instrQ[12];
  assign isLoad    = instrQ[11];
  assign offField  = instrQ[10:6];
  assign rfBaseIdx = instrQ[5:3];
  assign rfDataIdx = instrQ[2:0];
  assign wbIdx     = instrQ[2:0];

  // Word offsets count words, byte offsets count bytes.
  assign offBytes = isByte ? {{(DW-5){1'b0}}, offField}
                           : {{(DW-7){1'b0}}, offField, 2'b00};
  assign memAddr  = rfBaseData + offBytes;
  assign lane     = memAddr[LANE_W-1:0];

  assign memReq   = strobe.issueAccess;
  assign memWe    = strobe.issueAccess && !isLoad;
  assign memBe    = isByte ? (LANES'(1) << lane) : {LANES{1'b1}};
  assign memWdata = isByte ? ({{(DW-8){1'b0}}, rfDataData[7:0]} << {lane, 3'b000})
                           : rfDataData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instrQ <= '0;
      laneQ  <= '0;
    end else begin
      if (strobe.loadInstr)   instrQ <= instrWord;
      if (strobe.captureLane) laneQ  <= lane;
    end
  end

  assign shiftedRd = memRdData >> {laneQ, 3'b000};
  assign wbData    = isByte ? {{(DW-8){1'b0}}, shiftedRd[7:0]} : memRdData;
endmodule

// File: rtl/lsImmUnit.sv
module lsImmUnit
  import lsImmPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        instrValid,
  input  logic [15:0] instrWord,
  output logic        busy,
  output logic [2:0]  rfBaseIdx,
  input  logic [31:0] rfBaseData,
  output logic [2:0]  rfDataIdx,
  input  logic [31:0] rfDataData,
  output logic        memReq,
  output logic        memWe,
  output logic [3:0]  memBe,
  output logic [31:0] memAddr,
  output logic [31:0] memWdata,
  input  logic        memRdValid,
  input  logic [31:0] memRdData,
  output logic        wbEn,
  output logic [2:0]  wbIdx,
  output logic [31:0] wbData
);
  lsStrobe_t strobe;
  logic [2:0] majorOp;
  logic isLoad;

  lsImmCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .majorOp(majorOp),
    .isLoad(isLoad), .memRdValid(memRdValid), .strobe(strobe),
    .busy(busy), .wbEn(wbEn)
  );

  lsImmDatapath #(.DW(XLEN), .RW(REG_IDX_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instrWord(instrWord),
    .majorOp(majorOp), .isLoad(isLoad),
    .rfBaseIdx(rfBaseIdx), .rfBaseData(rfBaseData),
    .rfDataIdx(rfDataIdx), .rfDataData(rfDataData),
    .memReq(memReq), .memWe(memWe), .memBe(memBe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdData(memRdData), .wbIdx(wbIdx), .wbData(wbData)
  );
endmodule

// File: rtl/lsImmChecker.sv
module lsImmChecker (
  input logic        clk,
  input logic        rstN,
  input logic        instrValid,
  input logic [15:0] instrWord,
  input logic        busy,
  input logic        memReq,
  input logic        memWe,
  input logic [3:0]  memBe,
  input logic        wbEn
);
  AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq); // R7
  AST_LOAD_WB_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe) |=> wbEn); // R7
  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe) |=> !wbEn); // R1
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ((&memBe) || ($countones(memBe) == 1))); // R2
  AST_BAD_OP_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !busy && instrWord[15:13] != 3'b011) |=> (!busy && !memReq)); // R8
  AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy); // R9
  AST_WB_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wbEn |-> busy); // R9
endmodule

bind lsImmUnit lsImmChecker chk_i (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
  .busy(busy), .memReq(memReq), .memWe(memWe), .memBe(memBe), .wbEn(wbEn)
);

// File: tb/lsImmUnit_tb.sv
module lsImmUnit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic busy, memReq, memWe, wbEn;
  logic [2:0] rfBaseIdx, rfDataIdx, wbIdx;
  logic [31:0] rfBaseData, rfDataData, memAddr, memWdata, wbData;
  logic [3:0] memBe;
  logic memRdValid = 1'b0;
  logic [31:0] memRdData = '0;

  logic [31:0] regs [8];
  logic [31:0] mem [256];
  int errors = 0, checks = 0, reqCount = 0, wbCount = 0;
  logic [31:0] lastAddr, lastWdata;
  logic [3:0] lastBe;

  always #4 clk = ~clk; // 125 MHz

  lsImmUnit dut_i (.*);

  assign rfBaseData = regs[rfBaseIdx];
  assign rfDataData = regs[rfDataIdx];

  always @(posedge clk) begin
    memRdValid <= 1'b0;
    if (memReq) begin
      reqCount++;
      lastAddr = memAddr; lastBe = memBe; lastWdata = memWdata;
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[9:2]][b*8 +: 8] <= memWdata[b*8 +: 8];
      end else begin
        memRdData  <= mem[memAddr[9:2]];
        memRdValid <= 1'b1;
      end
    end
    if (wbEn) begin
      wbCount++;
      regs[wbIdx] <= wbData;
    end
  end

  function automatic logic [15:0] enc(bit b, bit l, logic [4:0] off, logic [2:0] rb, logic [2:0] rd);
    return {3'b011, b, l, off, rb, rd};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic [15:0] w);
    @(negedge clk);
    instrWord = w; instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0;
    for (int i = 0; i < 10 && busy; i++) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R10 busy", busy, 0);
    chk("R10 memReq", memReq, 0);
    chk("R10 wbEn", wbEn, 0);
  endtask

  task automatic testWordLoad();
    int wb0 = wbCount;
    regs[5] = 32'h40; regs[2] = 0;
    mem[(32'h40 + 116) >> 2] = 32'hDEAD_BEEF;
    issue(enc(0, 1, 5'd29, 3'd5, 3'd2));
    chk("R3 word addr", lastAddr, 32'hB4);
    chk("R2 word be", {28'b0, lastBe}, 32'hF);
    chk("R1 load value", regs[2], 32'hDEAD_BEEF);
    chk("R1 load wb count", wbCount - wb0, 1);
  endtask

  task automatic testByteStore();
    int wb0 = wbCount;
    regs[0] = 32'h20; regs[1] = 32'hA5A5_5A3C;
    mem[32'h2C >> 2] = 32'h1122_3344;
    issue(enc(1, 0, 5'd13, 3'd0, 3'd1));
    chk("R4 byte addr", lastAddr, 32'h2D);
    chk("R5 byte be", {28'b0, lastBe}, 32'h2);
    chk("R5 byte lane data", mem[32'h2C >> 2], 32'h1122_3C44);
    chk("R1 store no wb", wbCount - wb0, 0);
  endtask

  task automatic testByteLoads();
    regs[3] = 32'h80;
    mem[32'h80 >> 2] = 32'h9F7E_C201;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] e;
      e = {24'b0, 8'(32'h9F7E_C201 >> (8 * k))};
      regs[4] = 32'hFFFF_FFFF;
      issue(enc(1, 1, 5'(k), 3'd3, 3'd4));
      chk("R6 byte load zext", regs[4], e);
      chk("R2 byte be onehot", {28'b0, lastBe}, 32'(1 << k));
    end
  endtask

  task automatic testWordStoreMax();
    int wb0 = wbCount;
    regs[6] = 32'h100; regs[7] = 32'h0BAD_F00D;
    issue(enc(0, 0, 5'd31, 3'd6, 3'd7));
    chk("R3 max word offset", lastAddr, 32'h17C);
    chk("R1 word store data", mem[32'h17C >> 2], 32'h0BAD_F00D);
    chk("R7 store no wb", wbCount - wb0, 0);
  endtask

  task automatic testTimingAndBusy();
    int r0 = reqCount;
    regs[5] = 32'h40; regs[6] = 32'h100;
    mem[32'h44 >> 2] = 32'h1234_5678;
    @(negedge clk);
    instrWord = enc(0, 1, 5'd1, 3'd5, 3'd6); instrValid = 1'b1;
    @(negedge clk);
    instrWord = enc(0, 0, 5'd0, 3'd6, 3'd6); // offered while busy
    chk("R7 req after accept", memReq, 1);
    chk("R9 busy during access", busy, 1);
    @(negedge clk);
    chk("R7 wbEn with rvalid", wbEn, memRdValid);
    chk("R7 wbEn asserted", wbEn, 1);
    chk("R7 wbIdx", wbIdx, 6);
    chk("R9 busy until done", busy, 1);
    instrValid = 1'b0;
    @(negedge clk);
    chk("R9 idle after load", busy, 0);
    repeat (3) @(negedge clk);
    chk("R9 busy offer ignored", reqCount - r0, 1);
    chk("R7 load data", regs[6], 32'h1234_5678);
  endtask

  task automatic testBadOpcode();
    int r0 = reqCount;
    @(negedge clk);
    instrWord = 16'h9A5B; instrValid = 1'b1;
    @(negedge clk);
    instrValid = 1'b0;
    chk("R8 no busy", busy, 0);
    chk("R8 no req", memReq, 0);
    repeat (2) @(negedge clk);
    chk("R8 req count", reqCount - r0, 0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) regs[i] = 0;
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testWordLoad();
    testByteStore();
    testByteLoads();
    testWordStoreMax();
    testTimingAndBusy();
    testBadOpcode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule